// File: doc/BRIEF.md
# Start/Stop Framed On-Demand Serial Link

This block pairs a transmitter and a receiver that move words over single-wire serial lanes. Each frame begins with a start bit of '1', carries the data bits least significant first, and ends with a stop bit of '0'. The idle line also sits at '0'. The local serial clock runs only while there is traffic. Here that clock is modelled as an enable flag, brought out on `tx_active` and `rx_active`.

On the transmit side, words enter a small buffer through a valid/ready handshake. The transmitter takes one word from the buffer and shifts out its frame. If the buffer still holds a word when the stop bit goes out, the next frame follows with no gap. Once the buffer is empty, the transmitter drops its enable and the line rests at '0'.

On the receive side, a low-to-high transition on lane 0 arms a flag. While the flag is set, a one-hot ring counter sequences the capture of the data bits on every lane. When the counter wraps, the receiver presents the parallel word with a one-cycle valid pulse and disarms itself. The following bit is then checked as a stop bit. All lanes share one flag, one enable and one ring counter, and each lane has its own shift register.

Top module: `serial_frame_link`

## Requirements
- R1: After reset, `tx_line` and `out_valid` are 0, `tx_active`, `rx_active` and `frame_err` are 0, and `in_ready` is 1.
- R2: A transmitted frame on each lane is exactly W+2 consecutive bit times: a '1', then the W data bits of that lane (lane l uses `in_data[l*W +: W]`), least significant bit first, then a '0'.
- R3: `tx_active` is high only while a frame is on the line. A single word keeps it high for exactly W+2 cycles. Afterwards `tx_line` stays at 0.
- R4: When the buffer holds a word at the stop-bit cycle, the next start bit follows in the very next cycle. Consecutive words form one unbroken active period of N×(W+2) cycles.
- R5: `in_ready` is high whenever the buffer holds fewer than DEPTH words. A word is accepted on an edge where both `in_valid` and `in_ready` are high. Accepted words are sent in arrival order, and `in_ready` falls once DEPTH words wait.
- R6: The receiver arms on a 0-to-1 transition of `rx_line[0]`, samples the W following bits, and then raises `out_valid` for exactly one cycle with the word on `out_data`.
- R7: Every lane carries independent data under the shared timing. Receiver lane l appears on `out_data[l*W +: W]`.
- R8: If any lane's bit after the data is not '0', `frame_err` goes high and stays high until reset. The word of that frame is still delivered.
- R9: While a frame is being captured, transitions on the line do not re-arm the receiver, so data with many 0-to-1 steps is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered to the transmit buffer |
| in_ready | output | 1 | Buffer has room |
| in_data | input | LANES*W | Word to send, lane l in bits l*W +: W |
| tx_line | output | LANES | Serial outputs, one per lane |
| tx_active | output | 1 | Transmit clock enable |
| rx_line | input | LANES | Serial inputs, lane 0 carries the arming edge |
| rx_active | output | 1 | Receive clock enable |
| out_valid | output | 1 | One-cycle pulse with a received word |
| out_data | output | LANES*W | Received word |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench targets several corner cases, each of which a specific bug would break:
- **Back-to-back frames.** If the transmitter waited a cycle between frames, the active period would break into separate pieces. If the receiver missed the stop-to-start edge of a following frame, words would be lost.
- **Buffer full.** When the buffer fills, a wrong full test would drop or duplicate words, and the loopback order check would catch it.
- **Alternating data.** Data full of 0-to-1 steps would corrupt the word if the receiver re-armed mid-frame.
- **Bad stop bit.** A frame driven by hand with a bad stop bit must set the error flag. A later good frame must leave the flag set, which shows that the flag does not clear by mistake.

// File: rtl/serial_frame_link.sv
module serial_frame_link #(
  parameter int W     = 8,
  parameter int LANES = 2,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES*W-1:0] in_data,
  output logic [LANES-1:0]   tx_line,
  output logic               tx_active,
  input  logic [LANES-1:0]   rx_line,
  output logic               rx_active,
  output logic               out_valid,
  output logic [LANES*W-1:0] out_data,
  output logic               frame_err
);
  localparam int FW = W + 2;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // word buffer
  logic [LANES*W-1:0] mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [CW-1:0]      cnt;
  logic               push, pop;

  // transmit side
  logic [FW-1:0] tx_ring;
  logic          tx_en;
  logic [FW-1:0] tx_sh [LANES];

  assign in_ready  = (cnt != CW'(DEPTH));
  assign push      = in_valid && in_ready;
  assign pop       = tx_ring[0] && (cnt != '0);
  assign tx_active = tx_en;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ring <= FW'(1);
      tx_en   <= 1'b0;
    end else if (tx_ring[0]) begin
      if (pop) begin
        tx_ring <= {tx_ring[FW-2:0], tx_ring[FW-1]};
        tx_en   <= 1'b1;
      end else begin
        tx_en   <= 1'b0;
      end
    end else if (tx_en) begin
      tx_ring <= {tx_ring[FW-2:0], tx_ring[FW-1]};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_tx
    always_ff @(posedge clk) begin
      if (!rst_n)
        tx_sh[l] <= '0;
      else if (pop)
        tx_sh[l] <= {1'b0, mem[rp][l*W +: W], 1'b1};
      else if (tx_en && !tx_ring[0])
        tx_sh[l] <= tx_sh[l] >> 1;
    end
    assign tx_line[l] = tx_en & tx_sh[l][0];
  end

  // receive side
  logic         prev0, rx_en, rx_chk, arm, done;
  logic [W-1:0] rx_ring;
  logic [W-1:0] rx_sh [LANES];
  logic [W-1:0] rx_q  [LANES];

  assign arm       = !rx_en && !rx_chk && rx_line[0] && !prev0;
  assign done      = rx_en && rx_ring[W-1];
  assign rx_active = rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev0     <= 1'b0;
      rx_en     <= 1'b0;
      rx_chk    <= 1'b0;
      rx_ring   <= W'(1);
      out_valid <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      prev0     <= rx_line[0];
      rx_chk    <= done;
      out_valid <= done;
      if (rx_chk && (rx_line != '0)) frame_err <= 1'b1;
      if (arm) begin
        rx_en   <= 1'b1;
        rx_ring <= W'(1);
      end else if (rx_en) begin
        rx_ring <= {rx_ring[W-2:0], rx_ring[W-1]};
        if (done) rx_en <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rx
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_sh[l] <= '0;
        rx_q[l]  <= '0;
      end else if (rx_en) begin
        rx_sh[l] <= {rx_line[l], rx_sh[l][W-1:1]};
        if (done) rx_q[l] <= {rx_line[l], rx_sh[l][W-1:1]};
      end
    end
    assign out_data[l*W +: W] = rx_q[l];
  end

  // checks
  p_stop_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_ring[0]) |-> (tx_line == '0));
  p_back2back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_ring[0] && cnt != '0) |=> (tx_line == {LANES{1'b1}}));
  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_en);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  p_hold_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !rx_ring[W-1]) |=> rx_en);
endmodule

// File: tb/sim_serial_frame_link.sv
`timescale 1ns/1ps
module sim_serial_frame_link;
  localparam int W = 8, L = 2, D = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [L*W-1:0] in_data = '0;
  logic [L-1:0] tx_line, rx_line, drv_line = '0;
  logic use_loop = 1;
  logic tx_active, rx_active, out_valid, frame_err;
  logic [L*W-1:0] out_data;

  assign rx_line = use_loop ? tx_line : drv_line;
  always #2.5 clk = ~clk;

  serial_frame_link #(.W(W), .LANES(L), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_line(tx_line), .tx_active(tx_active),
    .rx_line(rx_line), .rx_active(rx_active), .out_valid(out_valid),
    .out_data(out_data), .frame_err(frame_err));

  int checks = 0, errors = 0;
  logic [L*W-1:0] rxq [64];
  int rx_n = 0, rises = 0, act_cyc = 0, dbl = 0;
  logic prev_ov = 0, prev_act = 0;
  logic saw_full = 0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (rx_n < 64) rxq[rx_n] = out_data;
      rx_n++;
    end
    if (out_valid && prev_ov) dbl++;
    if (tx_active && !prev_act) rises++;
    if (tx_active) act_cyc++;
    prev_ov = out_valid;
    prev_act = tx_active;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    rx_n = 0; rises = 0; act_cyc = 0; dbl = 0; saw_full = 0;
  endtask

  task automatic push(input logic [L*W-1:0] d);
    in_valid = 1; in_data = d;
    while (!in_ready) begin saw_full = 1; @(negedge clk); end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 2000 && rx_n < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [L*W-1:0] d, input logic stopv);
    @(negedge clk); drv_line = '1;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) drv_line[l] = d[l*W + i];
    end
    @(negedge clk); drv_line = {L{stopv}};
    @(negedge clk); drv_line = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_line == '0 && tx_active == 0, "R1 tx idle", {tx_line, tx_active}, 0);
    chk(out_valid == 0 && rx_active == 0, "R1 rx idle", {out_valid, rx_active}, 0);
    chk(frame_err == 0, "R1 frame_err", frame_err, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_format();
    logic [L-1:0] bits [W+2];
    logic [L*W-1:0] d = 16'hA53C;
    bit found = 0;
    use_loop = 1; clr();
    @(negedge clk);
    push(d);
    for (int i = 0; i < 20 && !found; i++) begin
      if (tx_line[0]) found = 1; else @(negedge clk);
    end
    chk(found, "R2 start seen", found, 1);
    bits[0] = tx_line;
    for (int i = 1; i < W + 2; i++) begin @(negedge clk); bits[i] = tx_line; end
    for (int l = 0; l < L; l++) begin
      logic [W-1:0] got;
      for (int i = 0; i < W; i++) got[i] = bits[i+1][l];
      chk(bits[0][l] == 1, "R2 start bit", bits[0][l], 1);
      chk(got == d[l*W +: W], "R2 data LSB first", got, d[l*W +: W]);
      chk(bits[W+1][l] == 0, "R2 stop bit", bits[W+1][l], 0);
    end
    wait_rx(1);
    chk(act_cyc == W + 2, "R3 active cycles", act_cyc, W + 2);
    chk(tx_active == 0 && tx_line == '0, "R3 idle after frame", {tx_active, tx_line}, 0);
    chk(rx_n == 1 && rxq[0] == d, "R6 loopback word", rxq[0], d);
    chk(dbl == 0, "R6 single-cycle valid", dbl, 0);
  endtask

  task automatic t_b2b();
    logic [L*W-1:0] w [3] = '{16'h1234, 16'hFEDC, 16'h00FF};
    use_loop = 1; clr();
    @(negedge clk);
    for (int i = 0; i < 3; i++) push(w[i]);
    wait_rx(3);
    chk(rises == 1, "R4 one active period", rises, 1);
    chk(act_cyc == 3 * (W + 2), "R4 contiguous cycles", act_cyc, 3 * (W + 2));
    chk(rx_n == 3, "R6 word count", rx_n, 3);
    for (int i = 0; i < 3; i++) chk(rxq[i] == w[i], "R4 order", rxq[i], w[i]);
    chk(dbl == 0, "R6 valid pulse width", dbl, 0);
  endtask

  task automatic t_full();
    int n = D + 3;
    use_loop = 1; clr();
    @(negedge clk);
    for (int i = 0; i < n; i++) push(16'h0101 * (i + 3));
    chk(saw_full, "R5 ready fell when full", saw_full, 1);
    wait_rx(n);
    chk(rx_n == n, "R5 all accepted words sent", rx_n, n);
    for (int i = 0; i < n; i++) chk(rxq[i] == 16'h0101 * (i + 3), "R5 order", rxq[i], 16'h0101 * (i + 3));
  endtask

  task automatic t_lanes();
    logic [L*W-1:0] w [3] = '{16'hFF00, 16'h00FF, 16'h817E};
    use_loop = 1; clr();
    @(negedge clk);
    for (int i = 0; i < 3; i++) push(w[i]);
    wait_rx(3);
    for (int i = 0; i < 3; i++) begin
      chk(rxq[i][W-1:0] == w[i][W-1:0], "R7 lane0", rxq[i][W-1:0], w[i][W-1:0]);
      chk(rxq[i][2*W-1:W] == w[i][2*W-1:W], "R7 lane1", rxq[i][2*W-1:W], w[i][2*W-1:W]);
    end
  endtask

  task automatic t_ignore();
    use_loop = 0; clr();
    rx_frame(16'h55AA, 1'b0);
    rx_frame(16'hAA55, 1'b0);
    chk(rx_n == 2, "R9 frames received", rx_n, 2);
    chk(rxq[0] == 16'h55AA, "R9 alternating word", rxq[0], 16'h55AA);
    chk(rxq[1] == 16'hAA55, "R9 alternating word 2", rxq[1], 16'hAA55);
    chk(frame_err == 0, "R8 no error on good stop", frame_err, 0);
  endtask

  task automatic t_ferr();
    use_loop = 0; clr();
    rx_frame(16'h3C5A, 1'b1);
    chk(frame_err == 1, "R8 bad stop flagged", frame_err, 1);
    chk(rx_n == 1 && rxq[0] == 16'h3C5A, "R8 word still delivered", rxq[0], 16'h3C5A);
    rx_frame(16'h1111, 1'b0);
    chk(frame_err == 1, "R8 flag sticky", frame_err, 1);
    chk(rx_n == 2 && rxq[1] == 16'h1111, "R8 later word", rxq[1], 16'h1111);
    use_loop = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_format();
    t_b2b();
    t_full();
    t_lanes();
    t_ignore();
    t_ferr();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule